// File: doc/BRIEF.md
# Triggered DAC Update Controller

This block sits between an APB bus and one 12-bit digital-to-analog converter channel. Software writes a target code into a value register. In immediate mode that code is carried to the converter on the next sample tick. In trigger mode the converter keeps its current code until a rising edge arrives on one of four external trigger lines, chosen by a select field. The trigger lines are asynchronous and pass through a two-flop synchronizer. Each trigger event sets a sticky status bit, which software clears by writing 1. When its enable bit is set, the status bit also drives an interrupt. This tells software that the next value can be loaded.

A programmable sample scaler paces all updates. It produces one tick every max(scaler, 1) clock cycles, and the code-valid strobe pulses once on each tick. An optional slew limiter makes the output move toward its target by at most 16 codes per tick. Without the limiter the output jumps to the target in a single tick. Clearing the enable bit stops the scaler, forces the code to zero, discards the held target and ignores triggers.

The output stage is a small state machine with three states. OST_OFF is the disabled state, with the code held at zero. OST_SETTLED means the code equals the target. OST_TRACK means the code is still moving toward the target. The transitions are:
- OST_OFF to OST_SETTLED once the block is enabled.
- OST_SETTLED to OST_TRACK when the target differs from the code.
- OST_TRACK to OST_SETTLED on a tick whose new code equals the target.
- Any state to OST_OFF when the enable bit is cleared.

Top module: `dac_trig_ctrl`

## Requirements
- R1: Registers are decoded at four word offsets, and every writable field reads back unchanged. pready is always 1, so there are no wait states.
  - 0x00 configuration: bit 0 enable, bit 1 trigger mode, bit 2 slew enable, bits 31:16 scaler.
  - 0x04 value: bits 11:0.
  - 0x08 sync: bits 1:0 trigger select, bit 2 interrupt enable.
  - 0x0C status: bit 0 trigger flag.
- R2: While enabled, the scaler ticks once every max(scaler, 1) clock cycles. dac_valid pulses high for exactly one cycle on each tick.
- R3: In immediate mode (configuration bit 1 = 0), a written value appears on dac_code at the first tick edge that falls three or more clock edges after the write's access edge.
- R4: In trigger mode (configuration bit 1 = 1), writes to the value register leave dac_code unchanged until a trigger event. The event latches the value register as the new target, and the code then follows it on later ticks.
- R5: A trigger event is a rising edge on trig_in[select], detected after a two-flop synchronizer. Edges on lines that are not selected have no effect.
- R6: Every trigger event while enabled sets status bit 0, in either mode and whatever the interrupt enable. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R7: irq equals status bit 0 AND sync bit 2.
- R8: With slew disabled, dac_code reaches the target in one tick.
- R9: With slew enabled, each tick moves dac_code toward the target by min(16, |target - code|).
- R10: While disabled, dac_code is 0 from the cycle after the disable, dac_valid stays low, and triggers neither set status nor latch a target. After re-enabling in trigger mode, the code stays 0 until a trigger.
- R11: After reset, dac_code, dac_valid and irq are 0, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| trig_in | input | 4 | Asynchronous trigger lines |
| dac_code | output | 12 | Code to the converter |
| dac_valid | output | 1 | One-cycle strobe per sample tick |
| irq | output | 1 | Trigger interrupt |

## Verification
The bench builds the block with its default parameters: 12-bit code, 16-bit scaler, four trigger lines and a step of 16. It programs the scaler with small values (0 to 8), so every tick interval can be measured and full slew ramps up to 4095 codes finish in a few thousand cycles. At these settings the bench can step a model of the output tick by tick through every ramp. It can also sweep every trigger select against every non-selected line, and it can place writes and trigger edges at known distances from a tick.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
    localparam int unsigned OFS_CFG  = 32'h00;
    localparam int unsigned OFS_VAL  = 32'h04;
    localparam int unsigned OFS_SYNC = 32'h08;
    localparam int unsigned OFS_STAT = 32'h0C;

    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_MODE_BIT = 1;
    localparam int CFG_SLEW_BIT = 2;
    localparam int CFG_SCL_LSB  = 16;
    localparam int SYNC_IE_BIT  = 2;

    typedef enum logic [1:0] {
        OST_OFF     = 2'd0,
        OST_SETTLED = 2'd1,
        OST_TRACK   = 2'd2
    } ost_e;
endpackage

// File: rtl/dac_apb_regs.sv
module dac_apb_regs
    import dac_trig_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12,
    parameter int SCL_W  = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic              trig_evt,
    output logic [31:0]       prdata,
    output logic              en_o,
    output logic              mode_o,
    output logic              slew_o,
    output logic [SCL_W-1:0]  scaler_o,
    output logic [DATA_W-1:0] value_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              irq_en_o,
    output logic              status_o
);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(OFS_VAL);
    localparam logic [ADDR_W-1:0] A_SYNC = ADDR_W'(OFS_SYNC);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic wr_acc;
    assign wr_acc = psel && penable && pwrite;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o     <= 1'b0;
            mode_o   <= 1'b0;
            slew_o   <= 1'b0;
            scaler_o <= '0;
            value_o  <= '0;
            sel_o    <= '0;
            irq_en_o <= 1'b0;
        end else if (wr_acc) begin
            if (paddr == A_CFG) begin
                en_o     <= pwdata[CFG_EN_BIT];
                mode_o   <= pwdata[CFG_MODE_BIT];
                slew_o   <= pwdata[CFG_SLEW_BIT];
                scaler_o <= pwdata[CFG_SCL_LSB +: SCL_W];
            end
            if (paddr == A_VAL) begin
                value_o <= pwdata[DATA_W-1:0];
            end
            if (paddr == A_SYNC) begin
                sel_o    <= pwdata[SEL_W-1:0];
                irq_en_o <= pwdata[SYNC_IE_BIT];
            end
        end
    end

    // Status flag: set on an event, cleared by writing 1; set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= 1'b0;
        end else if (trig_evt) begin
            status_o <= 1'b1;
        end else if (wr_acc && paddr == A_STAT && pwdata[0]) begin
            status_o <= 1'b0;
        end
    end

    always_comb begin
        prdata = '0;
        if (paddr == A_CFG) begin
            prdata[CFG_EN_BIT]               = en_o;
            prdata[CFG_MODE_BIT]             = mode_o;
            prdata[CFG_SLEW_BIT]             = slew_o;
            prdata[CFG_SCL_LSB +: SCL_W]     = scaler_o;
        end else if (paddr == A_VAL) begin
            prdata[DATA_W-1:0] = value_o;
        end else if (paddr == A_SYNC) begin
            prdata[SEL_W-1:0]  = sel_o;
            prdata[SYNC_IE_BIT] = irq_en_o;
        end else if (paddr == A_STAT) begin
            prdata[0] = status_o;
        end
    end

    assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt |=> status_o);
endmodule

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
    parameter int NTRIG = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_in,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic             trig_evt
);
    logic [NTRIG-1:0] rise;

    generate
        for (genvar g = 0; g < NTRIG; g++) begin : g_line
            logic [2:0] shreg;
            always_ff @(posedge clk) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[1:0], trig_in[g]};
            end
            assign rise[g] = shreg[1] && !shreg[2];
        end
    endgenerate

    always_comb begin
        trig_evt = 1'b0;
        if (en && (int'(sel) < NTRIG)) trig_evt = rise[sel];
    end
endmodule

// File: rtl/dac_pacer.sv
module dac_pacer #(
    parameter int SCL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SCL_W-1:0] scaler,
    output logic             tick
);
    logic [SCL_W-1:0] cnt_q;
    logic [SCL_W-1:0] lim;

    assign lim  = (scaler == '0) ? '0 : scaler - 1'b1;
    assign tick = en && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n || !en)   cnt_q <= '0;
        else if (tick)       cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && scaler > SCL_W'(1)) |=> (!tick || scaler <= SCL_W'(1)));
endmodule

// File: rtl/dac_out_stage.sv
module dac_out_stage
    import dac_trig_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int STEP   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mode,
    input  logic              slew_en,
    input  logic [DATA_W-1:0] value,
    input  logic              trig_evt,
    input  logic              tick,
    output logic [DATA_W-1:0] code_q,
    output logic              valid_q
);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    ost_e              state_q, state_d;
    logic [DATA_W-1:0] target_q;
    logic [DATA_W-1:0] gap, step, nxt;
    logic              up;

    // Target: follows the value register, or latches it on a trigger
    always_ff @(posedge clk) begin
        if (!rst_n || !en)      target_q <= '0;
        else if (!mode)         target_q <= value;
        else if (trig_evt)      target_q <= value;
    end

    always_comb begin
        up  = (target_q >= code_q);
        gap = up ? (target_q - code_q) : (code_q - target_q);
        step = (slew_en && gap > STEP_V) ? STEP_V : gap;
        nxt = up ? (code_q + step) : (code_q - step);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = OST_OFF;
        end else begin
            unique case (state_q)
                OST_OFF:     state_d = OST_SETTLED;
                OST_SETTLED: if (target_q != code_q) state_d = OST_TRACK;
                OST_TRACK:   if (tick && nxt == target_q) state_d = OST_SETTLED;
                default:     state_d = OST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= tick && en;
            if (!en)                              code_q <= '0;
            else if (state_q == OST_TRACK && tick) code_q <= nxt;
        end
    end

    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(code_q));

    assert_step_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slew_en) |=>
        (((code_q >= $past(code_q)) ? (code_q - $past(code_q)) : ($past(code_q) - code_q)) <= STEP_V));

    assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (code_q == '0));
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12,
    parameter int SCL_W  = 16,
    parameter int NTRIG  = 4,
    parameter int STEP   = 16
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic [NTRIG-1:0]  trig_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              dac_valid,
    output logic              irq
);
    localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

    logic              en, mode, slew, irq_en, status, trig_evt, tick;
    logic [SCL_W-1:0]  scaler;
    logic [DATA_W-1:0] value;
    logic [SEL_W-1:0]  sel;

    assign pready = 1'b1;
    assign irq    = status && irq_en;

    dac_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCL_W(SCL_W), .SEL_W(SEL_W)) u_regs (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .trig_evt(trig_evt), .prdata(prdata),
        .en_o(en), .mode_o(mode), .slew_o(slew), .scaler_o(scaler), .value_o(value),
        .sel_o(sel), .irq_en_o(irq_en), .status_o(status)
    );

    dac_trig_sync #(.NTRIG(NTRIG), .SEL_W(SEL_W)) u_trig (
        .clk(pclk), .rst_n(presetn), .trig_in(trig_in), .sel(sel), .en(en),
        .trig_evt(trig_evt)
    );

    dac_pacer #(.SCL_W(SCL_W)) u_pacer (
        .clk(pclk), .rst_n(presetn), .en(en), .scaler(scaler), .tick(tick)
    );

    dac_out_stage #(.DATA_W(DATA_W), .STEP(STEP)) u_out (
        .clk(pclk), .rst_n(presetn), .en(en), .mode(mode), .slew_en(slew),
        .value(value), .trig_evt(trig_evt), .tick(tick),
        .code_q(dac_code), .valid_q(dac_valid)
    );

    assert_valid_needs_en_R10: assert property (@(posedge pclk) disable iff (!presetn)
        !en |=> !dac_valid);
endmodule

// File: tb/sim_dac_trig_ctrl.sv
module sim_dac_trig_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [3:0]  trig = '0;
    logic [11:0] code;
    logic        valid, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_trig_ctrl u0 (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .trig_in(trig), .dac_code(code), .dac_valid(valid), .irq(irq)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!valid);
    endtask

    function automatic logic [31:0] cfgw(input bit en, input bit md, input bit sl, input int sc);
        return {sc[15:0], 13'b0, sl, md, en};
    endfunction

    function automatic logic [11:0] step_to(input logic [11:0] cur, input logic [11:0] tgt, input bit sl);
        int d;
        d = int'(tgt) - int'(cur);
        if (!sl) return tgt;
        if (d > 16)  return cur + 12'd16;
        if (d < -16) return cur - 12'd16;
        return tgt;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [11:0] model, prev, tv;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        chk("R11 code", code, 0);
        chk("R11 valid", valid, 0);
        chk("R11 irq", irq, 0);
        for (int a = 0; a < 16; a += 4) begin
            apb_rd(a[7:0], rd);
            chk("R11 reg", rd, 0);
        end

        // R1 readback
        apb_wr(8'h00, cfgw(0, 1, 1, 16'hA5C));
        apb_rd(8'h00, rd); chk("R1 cfg", rd, cfgw(0, 1, 1, 16'hA5C));
        apb_wr(8'h04, 32'h0000_0ABC);
        apb_rd(8'h04, rd); chk("R1 value", rd, 32'hABC);
        apb_wr(8'h08, 32'h0000_0007);
        apb_rd(8'h08, rd); chk("R1 sync", rd, 32'h7);
        chk("R1 pready", pready, 1);
        apb_wr(8'h04, 0);
        apb_wr(8'h08, 0);

        // R2 scaler interval sweep
        for (int sc = 0; sc <= 7; sc++) begin
            int n;
            apb_wr(8'h00, cfgw(1, 0, 0, sc));
            wait_strobe();
            n = 0;
            do begin @(negedge clk); n++; end while (!valid);
            chk("R2 interval", n, (sc < 1) ? 1 : sc);
        end

        // R3 / R8 immediate mode, no slew
        apb_wr(8'h00, cfgw(1, 0, 0, 8));
        for (int i = 0; i < 14; i++) begin
            tv = 12'(i * 12'h137 ^ 12'hA5A);
            if (i == 0) tv = 12'hFFF;
            if (i == 1) tv = 12'h000;
            wait_strobe();
            prev = code;
            apb_wr(8'h04, {20'b0, tv});
            chk("R3 no change before tick", code, prev);
            wait_strobe();
            chk("R8 jump in one tick", code, tv);
        end

        // R9 slew ramps
        wait_strobe();
        apb_wr(8'h04, 0);
        wait_strobe(); wait_strobe();
        apb_wr(8'h00, cfgw(1, 0, 1, 8));
        model = 0;
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: tv = 12'h035;
                1: tv = 12'hFFF;
                2: tv = 12'h7F3;
                3: tv = 12'h7E8;
                4: tv = 12'h009;
                default: tv = 12'h100;
            endcase
            wait_strobe();
            chk("R9 settled start", code, model);
            apb_wr(8'h04, {20'b0, tv});
            while (model != tv) begin
                wait_strobe();
                model = step_to(model, tv, 1'b1);
                chk("R9 slew step", code, model);
            end
        end

        // R6 in immediate mode: trigger sets status
        apb_wr(8'h08, 32'h0000_0001);
        wait_strobe();
        trig[1] = 1; repeat (4) @(negedge clk); trig[1] = 0;
        apb_rd(8'h0C, rd); chk("R6 status immediate mode", rd, 1);
        chk("R7 irq off when disabled", irq, 0);
        apb_wr(8'h0C, 0);
        apb_rd(8'h0C, rd); chk("R6 write 0 keeps", rd, 1);
        apb_wr(8'h0C, 1);
        apb_rd(8'h0C, rd); chk("R6 w1c clears", rd, 0);

        // R4 / R5 / R6 / R7 trigger mode sweep over selects
        apb_wr(8'h00, cfgw(1, 1, 0, 8));
        for (int s = 0; s < 4; s++) begin
            tv = 12'(12'h111 * (s + 3));
            apb_wr(8'h08, 32'(s) | 32'h4);
            wait_strobe();
            prev = code;
            apb_wr(8'h04, {20'b0, ~tv});
            apb_wr(8'h04, {20'b0, tv});
            wait_strobe(); wait_strobe();
            chk("R4 hold without trigger", code, prev);
            for (int o = 0; o < 4; o++) begin
                if (o != s) begin
                    trig[o] = 1; repeat (4) @(negedge clk); trig[o] = 0;
                end
            end
            wait_strobe(); wait_strobe();
            chk("R5 other lines ignored code", code, prev);
            apb_rd(8'h0C, rd); chk("R5 other lines ignored status", rd, 0);
            chk("R7 irq low", irq, 0);
            wait_strobe();
            trig[s] = 1; repeat (4) @(negedge clk); trig[s] = 0;
            wait_strobe(); wait_strobe();
            chk("R4 code after trigger", code, tv);
            chk("R7 irq high", irq, 1);
            apb_wr(8'h0C, 1);
            chk("R7 irq after clear", irq, 0);
        end

        // R6 without interrupt enable
        apb_wr(8'h08, 32'h0000_0002);
        trig[2] = 1; repeat (4) @(negedge clk); trig[2] = 0;
        repeat (2) @(negedge clk);
        apb_rd(8'h0C, rd); chk("R6 status with irq disabled", rd, 1);
        chk("R7 irq masked", irq, 0);
        apb_wr(8'h0C, 1);

        // R10 disable
        apb_wr(8'h00, cfgw(0, 1, 0, 8));
        @(negedge clk);
        chk("R10 code zero", code, 0);
        begin
            int nv = 0;
            apb_wr(8'h04, 32'h0000_0321);
            trig[2] = 1; repeat (4) @(negedge clk); trig[2] = 0;
            for (int c = 0; c < 40; c++) begin @(negedge clk); if (valid) nv++; end
            chk("R10 no strobes", nv, 0);
            chk("R10 code still zero", code, 0);
        end
        apb_rd(8'h0C, rd); chk("R10 trigger ignored", rd, 0);
        apb_wr(8'h00, cfgw(1, 1, 0, 8));
        wait_strobe(); wait_strobe();
        chk("R10 no latched target", code, 0);
        trig[2] = 1; repeat (4) @(negedge clk); trig[2] = 0;
        wait_strobe(); wait_strobe();
        chk("R4 trigger after re-enable", code, 12'h321);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule